// File: doc/BRIEF.md
# Multicart Outer Bank Register with Lock

This block sits next to an inner bank-switching controller on a multi-game cartridge for an 8-bit console. It catches CPU writes that fall in the 0x6000–0x7FFF window and stores the data byte in one 8-bit outer register. CPU writes to 0x8000–0xFFFF go through unchanged to the inner controller. Three scattered register bits form a 4-bit outer field. The block joins that field with the inner controller's 8 KiB program bank number and 1 KiB pattern bank number. The results are the final ROM bank numbers, so each game is confined to its own 256 KiB program slice and 128 KiB pattern slice.

Register bit 7 is a sticky lock. After it is set, the register ignores all further writes until a hard reset. A soft reset leaves the register unchanged and is only passed on to the inner controller. The window has no work RAM, so CPU reads there leave the data bus undriven.

Top module: `mc_outer_bank`

## Requirements
- R1: A CPU write whose address is in 0x6000–0x7FFF loads the whole data byte into the outer register on the clock edge. Both window edges are included. Writes to 0x5FFF or 0x8000 leave the register unchanged.
- R2: A CPU write to 0x8000–0xFFFF raises `inner_wr` in the same cycle, with `inner_addr` and `inner_wdata` equal to the CPU address and data. Writes outside that range keep `inner_wr` low.
- R3: While register bit 7 is 1, writes to the window are ignored. The lock test uses the value held before the write, so the write that sets bit 7 does take effect.
- R4: `hard_rst_n` is a synchronous active-low reset. It sets the register to 0x00, which also clears the lock.
- R5: `soft_rst_n` has no effect on the register or the lock. It is copied to `inner_soft_rst_n`.
- R6: The outer field is {reg[5], reg[2], reg[1], 0}. Register bits 0, 3, 4, 6 and 7 have no effect on any bank output.
- R7: `prg_bank` = (field << 4) | (`inner_prg` & 0x1F), 8 bits wide.
- R8: `chr_bank` = (field << 6) | (`inner_chr` & 0x7F), 10 bits wide. This single value addresses pattern memory for both reads and writes.
- R9: `rd_drive_en` is 1 for a CPU read of 0x8000–0xFFFF. It is 0 for a read in 0x6000–0x7FFF and whenever no read is under way.
- R10: The bank outputs are combinational from the register and the inner bank inputs. A window write changes the mapping in the cycle after its clock edge, and a change on an inner input shows without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst_n | input | 1 | Active-low soft reset request |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| inner_prg | input | 8 | Inner controller 8 KiB program bank number |
| inner_chr | input | 8 | Inner controller 1 KiB pattern bank number |
| inner_wr | output | 1 | Forwarded write strobe to inner controller |
| inner_addr | output | 16 | Forwarded write address |
| inner_wdata | output | 8 | Forwarded write data |
| inner_soft_rst_n | output | 1 | Soft reset passed to inner controller |
| rd_drive_en | output | 1 | Cartridge drives CPU data bus for this read |
| prg_bank | output | 8 | Final 8 KiB program bank number |
| chr_bank | output | 10 | Final 1 KiB pattern bank number |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, 8-bit inner bank inputs, a 4-bit outer field, and inner keep widths of 5 and 7 bits. These values are small enough for a full sweep. The bench loads each of the 256 register values from a hard-reset start. For each loaded value it steps both inner bank inputs through all 256 codes. This covers every ignored bit, every lock setting and the overlap at program bank bit 4, where the field's zero bit meets inner bit 4. Around the sweep, directed writes probe the window edges, the forwarding path, soft and hard reset, and the bus-drive decision for reads.

// File: rtl/mc_ob_pkg.sv
// Shared constants and the outer-field extraction for the outer bank block.
// Assumes an 8-bit register whose scattered bits form a 4-bit field.
package mc_ob_pkg;
    localparam int unsigned REG_W     = 8;
    localparam int unsigned FIELD_W   = 4;
    localparam int unsigned LOCK_BIT  = 7;

    // Gather reg bits 5,2,1 into field bits 3,2,1; field bit 0 is always zero.
    function automatic logic [FIELD_W-1:0] field_of(input logic [REG_W-1:0] r);
        return {r[5], r[2], r[1], 1'b0};
    endfunction
endpackage

// File: rtl/mc_ob_decode.sv
// Address decoder: splits CPU cycles into register-window writes,
// pass-through writes and bus-driving reads.
// Assumes a 16-bit CPU address; the window is 0x6000-0x7FFF, cartridge ROM is 0x8000-0xFFFF.
module mc_ob_decode #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic          rd,
    output logic          win_wr,
    output logic          fwd_wr,
    output logic          rd_drive
);
    logic in_win;
    logic in_rom;

    // Window and ROM-range match from the top address bits.
    always_comb begin
        in_win   = (addr[AW-1 -: 3] == 3'b011);
        in_rom   = addr[AW-1];
        win_wr   = wr & in_win;
        fwd_wr   = wr & in_rom;
        rd_drive = rd & in_rom;
    end

    // R2
    fwd_not_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_wr && win_wr));
    // R9
    no_drive_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr[AW-1 -: 3] == 3'b011) |-> !rd_drive);
endmodule

// File: rtl/mc_ob_reg.sv
// Outer register with sticky lock: loads on an unlocked window write,
// cleared only by the synchronous active-low hard reset.
// Assumes the lock flag lives in register bit LOCK_BIT.
module mc_ob_reg
    import mc_ob_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] reg_q
);
    logic locked;
    assign locked = reg_q[LOCK_BIT];

    // Hold or load the register; the lock test uses the pre-write value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (win_wr && !locked)
            reg_q <= wdata;
    end

    // R3
    lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(reg_q));
    // R1
    load_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && !locked) |=> reg_q == $past(wdata));
    // R4
    hard_reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> reg_q == '0);
endmodule

// File: rtl/mc_ob_join.sv
// Joins the outer field, shifted up by SHIFT, with the low KEEP bits of an inner bank number.
// Assumes KEEP <= OUTER_W + SHIFT and KEEP <= IN_W.
module mc_ob_join #(
    parameter int unsigned OUTER_W = 4,
    parameter int unsigned IN_W    = 8,
    parameter int unsigned SHIFT   = 4,
    parameter int unsigned KEEP    = 5,
    localparam int unsigned OUT_W  = OUTER_W + SHIFT
) (
    input  logic [OUTER_W-1:0] field,
    input  logic [IN_W-1:0]    inner,
    output logic [OUT_W-1:0]   bank
);
    logic [OUT_W-1:0] kept;

    // Mask the inner number to KEEP bits and OR in the shifted field.
    always_comb begin
        kept = '0;
        kept[KEEP-1:0] = inner[KEEP-1:0];
        bank = {field, {SHIFT{1'b0}}} | kept;
    end
endmodule

// File: rtl/mc_outer_bank.sv
// Top: outer bank register with lock for a multi-game cartridge.
// Decodes CPU writes, keeps the locked outer register, forwards inner
// controller traffic and forms final program and pattern bank numbers.
// Assumes the inner controller's banking logic is outside and supplies its bank numbers.
module mc_outer_bank
    import mc_ob_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned INNER_W   = 8,
    parameter int unsigned PRG_SHIFT = 4,
    parameter int unsigned PRG_KEEP  = 5,
    parameter int unsigned CHR_SHIFT = 6,
    parameter int unsigned CHR_KEEP  = 7,
    localparam int unsigned PRG_W    = FIELD_W + PRG_SHIFT,
    localparam int unsigned CHR_W    = FIELD_W + CHR_SHIFT
) (
    input  logic               clk,
    input  logic               hard_rst_n,
    input  logic               soft_rst_n,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [REG_W-1:0]   cpu_wdata,
    input  logic               cpu_wr,
    input  logic               cpu_rd,
    input  logic [INNER_W-1:0] inner_prg,
    input  logic [INNER_W-1:0] inner_chr,
    output logic               inner_wr,
    output logic [AW-1:0]      inner_addr,
    output logic [REG_W-1:0]   inner_wdata,
    output logic               inner_soft_rst_n,
    output logic               rd_drive_en,
    output logic [PRG_W-1:0]   prg_bank,
    output logic [CHR_W-1:0]   chr_bank
);
    logic               win_wr;
    logic [REG_W-1:0]   outer_q;
    logic [FIELD_W-1:0] field;

    mc_ob_decode #(.AW(AW)) dec_i (
        .clk(clk), .rst_n(hard_rst_n), .addr(cpu_addr), .wr(cpu_wr), .rd(cpu_rd),
        .win_wr(win_wr), .fwd_wr(inner_wr), .rd_drive(rd_drive_en)
    );

    mc_ob_reg reg_i (
        .clk(clk), .rst_n(hard_rst_n), .win_wr(win_wr), .wdata(cpu_wdata), .reg_q(outer_q)
    );

    // Pass-through paths and outer field extraction.
    always_comb begin
        inner_addr       = cpu_addr;
        inner_wdata      = cpu_wdata;
        inner_soft_rst_n = soft_rst_n;
        field            = field_of(outer_q);
    end

    mc_ob_join #(.OUTER_W(FIELD_W), .IN_W(INNER_W), .SHIFT(PRG_SHIFT), .KEEP(PRG_KEEP)) prg_join_i (
        .field(field), .inner(inner_prg), .bank(prg_bank)
    );

    mc_ob_join #(.OUTER_W(FIELD_W), .IN_W(INNER_W), .SHIFT(CHR_SHIFT), .KEEP(CHR_KEEP)) chr_join_i (
        .field(field), .inner(inner_chr), .bank(chr_bank)
    );

    // R5
    soft_reset_keeps_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!soft_rst_n && !cpu_wr) |=> $stable(outer_q));
    // R10
    map_stable_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        ($stable(outer_q) && $stable(inner_prg) && $stable(inner_chr))
            |-> ($stable(prg_bank) && $stable(chr_bank)));
    // R6
    ignored_bits_chk: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (outer_q[5] == $past(outer_q[5]) && outer_q[2:1] == $past(outer_q[2:1]) && $stable(inner_prg))
            |-> $stable(prg_bank));
endmodule

// File: tb/mc_outer_bank_tb.sv
`timescale 1ns/1ps
module mc_outer_bank_tb_top;
    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0;
    logic        soft_rst_n = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  inner_prg = '0;
    logic [7:0]  inner_chr = '0;
    logic        inner_wr;
    logic [15:0] inner_addr;
    logic [7:0]  inner_wdata;
    logic        inner_soft_rst_n;
    logic        rd_drive_en;
    logic [7:0]  prg_bank;
    logic [9:0]  chr_bank;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] model;

    always #2 clk = ~clk;

    mc_outer_bank dut_i (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .inner_prg(inner_prg), .inner_chr(inner_chr),
        .inner_wr(inner_wr), .inner_addr(inner_addr), .inner_wdata(inner_wdata),
        .inner_soft_rst_n(inner_soft_rst_n), .rd_drive_en(rd_drive_en),
        .prg_bank(prg_bank), .chr_bank(chr_bank)
    );

    function automatic logic [3:0] fld(input logic [7:0] r);
        return {r[5], r[2], r[1], 1'b0};
    endfunction
    function automatic logic [7:0] exp_prg(input logic [7:0] r, input logic [7:0] i);
        return {fld(r), 4'b0} | {3'b0, i[4:0]};
    endfunction
    function automatic logic [9:0] exp_chr(input logic [7:0] r, input logic [7:0] i);
        return {fld(r), 6'b0} | {3'b0, i[6:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        if (a >= 16'h6000 && a <= 16'h7FFF && !model[7]) model = d;
    endtask

    task automatic do_hard_reset();
        @(negedge clk); hard_rst_n = 1'b0;
        @(negedge clk); hard_rst_n = 1'b1;
        model = 8'h00;
    endtask

    task automatic check_map(input string req);
        #0.5;
        chk(req, {24'b0, prg_bank}, {24'b0, exp_prg(model, inner_prg)});
        chk(req, {22'b0, chr_bank}, {22'b0, exp_chr(model, inner_chr)});
    endtask

    initial begin
        #(200000 * 4);
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model = 8'h00;
        // R4: reset state
        do_hard_reset();
        inner_prg = 8'hFF; inner_chr = 8'hFF;
        check_map("R4");

        // R1 boundaries
        cpu_write(16'h5FFF, 8'h26); check_map("R1");
        cpu_write(16'h8000, 8'h26); check_map("R1");
        cpu_write(16'h7FFF, 8'h02); check_map("R1");
        cpu_write(16'h6000, 8'h24); check_map("R1");

        // R2 forwarding, sampled during the write cycle
        @(negedge clk);
        cpu_addr = 16'hA001; cpu_wdata = 8'h5A; cpu_wr = 1'b1;
        #0.5;
        chk("R2", {31'b0, inner_wr}, 32'd1);
        chk("R2", {16'b0, inner_addr}, 32'hA001);
        chk("R2", {24'b0, inner_wdata}, 32'h5A);
        cpu_addr = 16'h6123;
        #0.5;
        chk("R2", {31'b0, inner_wr}, 32'd0);
        @(negedge clk); cpu_wr = 1'b0;
        model = 8'h5A;
        check_map("R1");
        cpu_addr = 16'h5000; cpu_wr = 1'b1; #0.5;
        chk("R2", {31'b0, inner_wr}, 32'd0);
        cpu_wr = 1'b0;

        // R9 read bus drive
        cpu_rd = 1'b1; cpu_addr = 16'h6000; #0.5;
        chk("R9", {31'b0, rd_drive_en}, 32'd0);
        cpu_addr = 16'h7FFF; #0.5;
        chk("R9", {31'b0, rd_drive_en}, 32'd0);
        cpu_addr = 16'h8000; #0.5;
        chk("R9", {31'b0, rd_drive_en}, 32'd1);
        cpu_rd = 1'b0; #0.5;
        chk("R9", {31'b0, rd_drive_en}, 32'd0);

        // R5 soft reset keeps register, is forwarded
        do_hard_reset();
        cpu_write(16'h6800, 8'hA6);
        @(negedge clk); soft_rst_n = 1'b0; #0.5;
        chk("R5", {31'b0, inner_soft_rst_n}, 32'd0);
        @(negedge clk); @(negedge clk); soft_rst_n = 1'b1;
        check_map("R5");
        chk("R5", {31'b0, inner_soft_rst_n}, 32'd1);
        cpu_write(16'h6000, 8'h00); check_map("R3");
        // R4 hard reset clears lock
        do_hard_reset(); check_map("R4");
        cpu_write(16'h6000, 8'h04); check_map("R4");

        // R6 R7 R8 R10 sweep over all register values and inner inputs
        for (int v = 0; v < 256; v++) begin
            do_hard_reset();
            cpu_write(16'h6000 + 16'((v * 37) % 8192), 8'(v));
            for (int i = 0; i < 256; i++) begin
                inner_prg = 8'(i); inner_chr = 8'(255 - i);
                #0.5;
                chk("R7", {24'b0, prg_bank}, {24'b0, exp_prg(8'(v), 8'(i))});
                chk("R8", {22'b0, chr_bank}, {22'b0, exp_chr(8'(v), 8'(255 - i))});
            end
            // R3 lock or R10 remap after a second write
            cpu_write(16'h7000, ~8'(v));
            check_map(v[7] ? "R3" : "R10");
            if (v[7]) chk("R3", {24'b0, prg_bank}, {24'b0, exp_prg(8'(v), inner_prg)});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule